// File: doc/BRIEF.md
# Two-Slot Receive Frame Assembler

The block takes an incoming Ethernet payload as a byte stream with start and end markers. It builds a complete frame image in one of two receive buffers of `BUF_BYTES` bytes each. A host arms each buffer by writing its slot state to "loaded". The block moves a slot to "pending" once a frame has been stored there. The host releases the slot by writing "empty" or "loaded" again.

The frame image has three parts. Eight bytes of preamble and start delimiter sit at the front. The payload follows, zero-padded to a minimum length. A CRC-32 frame check sequence closes the image. The payload is written as it arrives. Padding and the check sequence follow the end marker, one byte per cycle. The eight leading bytes are written last, and the slot becomes pending on that final write. The block reports the total image length in a count register for each slot. An interrupt stays high while either slot is pending. The buffer write port is a plain byte write strobe with a slot select and an address.

Top module: `rx_frame_slots`

## Requirements
- R1: Slot states use the encoding 0 = empty, 1 = loaded, 2 = pending. A host write (`st_we_i`, slot `st_sel_i`, value `st_data_i`) takes effect on the next clock edge. After reset both states and both counts are 0 and `irq_o` is low.
- R2: A frame start goes to slot 0 if slot 0 is loaded, otherwise to slot 1 if slot 1 is loaded. `buf_slot_o` names the slot being written.
- R3: Buffer offsets 0 to 6 hold 0x55, offset 7 holds 0xD5, and payload byte k is written at offset 8 + k.
- R4: A payload shorter than `MIN_PAYLOAD` (60) bytes is followed by zero bytes up to 60 bytes.
- R5: The check value is CRC-32 with reflected polynomial 0xEDB88320, initial value all ones and final inversion, over payload and padding only. Its four bytes are stored least significant first, starting at offset 8 + padded length.
- R6: After the end beat is accepted, the block writes the pad bytes, then the 4 check bytes, then the 8 leading bytes, one per cycle. On the edge that issues the offset-7 write, the slot state becomes 2 and its count becomes padded length + 12. The change is visible pad + 12 cycles after the end-beat edge.
- R7: A payload longer than `BUF_BYTES` - 12 bytes is dropped. The slot state and count stay unchanged, and nothing is written at offsets from `BUF_BYTES` - 4 upward.
- R8: `irq_o` is high exactly when at least one slot state equals 2. It follows host writes and commits in the same cycle the state changes.
- R9: `in_ready_o` behaves as follows. While idle it is high exactly when a slot is loaded. While payload is being received it is high. While pad, check or leading bytes are being written it is low.
- R10: While idle, an accepted byte without the start marker is discarded. It causes no buffer write and does not start a frame.
- R11: A host write and a frame commit on the same edge behave as follows. If both target the same slot, the commit wins (state 2). If they target different slots, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Payload byte valid |
| in_data_i | input | 8 | Payload byte |
| in_sop_i | input | 1 | First byte of a frame |
| in_eop_i | input | 1 | Last byte of a frame |
| in_ready_o | output | 1 | Byte accepted when high with valid |
| st_we_i | input | 1 | Host slot state write strobe |
| st_sel_i | input | 1 | Slot addressed by the host write |
| st_data_i | input | 2 | Slot state value written |
| buf_we_o | output | 1 | Buffer byte write strobe |
| buf_slot_o | output | 1 | Buffer (slot) being written |
| buf_addr_o | output | ADDR_W | Byte offset within the buffer |
| buf_data_o | output | 8 | Byte written |
| state0_o | output | 2 | Slot 0 state |
| state1_o | output | 2 | Slot 1 state |
| count0_o | output | CNT_W | Slot 0 stored image length |
| count1_o | output | CNT_W | Slot 1 stored image length |
| irq_o | output | 1 | Receive interrupt, level |

## Verification
A host write to a slot state register can land on the same edge as the commit of a finished frame. The bench provokes this by driving the host strobe in the half cycle before the predicted commit edge. It does so in two cases: the write addresses the slot being committed, and the write addresses the other slot. The reference model then expects, respectively, the pending state to win, or both updates to apply. The bench compares both states and the interrupt in the following cycle.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  typedef enum logic [1:0] {
    SLOT_EMPTY   = 2'd0,
    SLOT_LOADED  = 2'd1,
    SLOT_PENDING = 2'd2
  } slot_state_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DATA,
    PH_PAD,
    PH_FCS,
    PH_PRE
  } phase_e;

  localparam int unsigned LEAD_LEN  = 8;
  localparam int unsigned FCS_LEN   = 4;
  localparam int unsigned OVERHEAD  = LEAD_LEN + FCS_LEN;
  localparam logic [7:0]  LEAD_BYTE = 8'h55;
  localparam logic [7:0]  SYNC_BYTE = 8'hD5;
  localparam logic [31:0] CRC_POLY  = 32'hEDB88320;

  function automatic logic [31:0] crc_step(input logic [31:0] crc, input logic [7:0] data);
    logic [31:0] c;
    c = crc ^ {24'd0, data};
    for (int b = 0; b < 8; b++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/rxs_slot.sv
module rxs_slot
  import rxs_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_we_i,
  input  logic [1:0]       host_state_i,
  input  logic             commit_i,
  input  logic [CNT_W-1:0] commit_cnt_i,
  output logic [1:0]       state_o,
  output logic [CNT_W-1:0] count_o
);

  logic [1:0]       state_q;
  logic [CNT_W-1:0] count_q;

  // commit outranks a coincident host write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SLOT_EMPTY;
      count_q <= '0;
    end else if (commit_i) begin
      state_q <= SLOT_PENDING;
      count_q <= commit_cnt_i;
    end else if (host_we_i) begin
      state_q <= host_state_i;
    end
  end

  assign state_o = state_q;
  assign count_o = count_q;

endmodule

// File: rtl/rxs_crc.sv
module rxs_crc
  import rxs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clear_i,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  output logic [31:0] crc_o
);

  logic [31:0] crc_q;
  logic [31:0] base;

  assign base = clear_i ? '1 : crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '1;
    else if (en_i)    crc_q <= crc_step(base, data_i);
    else if (clear_i) crc_q <= '1;
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/rxs_seq.sv
module rxs_seq
  import rxs_pkg::*;
#(
  parameter int unsigned BUF_BYTES   = 2048,
  parameter int unsigned MIN_PAYLOAD = 60,
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned CNT_W       = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  output logic              in_ready_o,
  input  logic [1:0]        loaded_i,
  output logic [1:0]        commit_o,
  output logic [CNT_W-1:0]  commit_cnt_o,
  output logic              crc_clear_o,
  output logic              crc_en_o,
  output logic [7:0]        crc_data_o,
  input  logic [31:0]       crc_i,
  output logic              buf_we_o,
  output logic              buf_slot_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [7:0]        buf_data_o,
  output logic              busy_o
);

  localparam int unsigned LEN_W = $clog2(BUF_BYTES + 1);
  localparam logic [LEN_W-1:0] MAX_L  = LEN_W'(BUF_BYTES - OVERHEAD);
  localparam logic [LEN_W-1:0] MIN_L  = LEN_W'(MIN_PAYLOAD);
  localparam logic [LEN_W-1:0] LEAD_L = LEN_W'(LEAD_LEN);

  phase_e            phase_q;
  logic              slot_q;
  logic [LEN_W-1:0]  len_q;
  logic [2:0]        idx_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;

  logic              idle, take_byte, room;
  logic [LEN_W-1:0]  cur_len, len_nx;
  logic [7:0]        fcs_byte;

  assign idle       = (phase_q == PH_IDLE);
  assign in_ready_o = idle ? |loaded_i : (phase_q == PH_DATA);
  assign take_byte  = in_valid_i && in_ready_o && (!idle || in_sop_i);
  assign cur_len    = idle ? '0 : len_q;
  assign room       = cur_len < MAX_L;
  assign len_nx     = room ? cur_len + LEN_W'(1) : cur_len;
  assign fcs_byte   = ~crc_i[8*idx_q[1:0] +: 8];

  assign crc_clear_o = take_byte && idle;
  assign crc_en_o    = (take_byte && room) || (phase_q == PH_PAD);
  assign crc_data_o  = (phase_q == PH_PAD) ? 8'h00 : in_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      slot_q  <= 1'b0;
      len_q   <= '0;
      idx_q   <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      we_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE, PH_DATA: begin
          if (take_byte) begin
            if (idle) slot_q <= loaded_i[0] ? 1'b0 : 1'b1;
            len_q <= len_nx;
            idx_q <= '0;
            if (room) begin
              we_q   <= 1'b1;
              addr_q <= ADDR_W'(cur_len + LEAD_L);
              data_q <= in_data_i;
            end
            if (!in_eop_i)     phase_q <= PH_DATA;
            else if (!room)    phase_q <= PH_IDLE;   // oversize: drop
            else if (len_nx < MIN_L) phase_q <= PH_PAD;
            else               phase_q <= PH_FCS;
          end
        end
        PH_PAD: begin
          we_q   <= 1'b1;
          addr_q <= ADDR_W'(len_q + LEAD_L);
          data_q <= 8'h00;
          len_q  <= len_q + LEN_W'(1);
          if (len_q + LEN_W'(1) == MIN_L) phase_q <= PH_FCS;
        end
        PH_FCS: begin
          we_q   <= 1'b1;
          addr_q <= ADDR_W'(len_q + LEAD_L + LEN_W'(idx_q));
          data_q <= fcs_byte;
          idx_q  <= idx_q + 3'd1;
          if (idx_q == 3'(FCS_LEN - 1)) begin
            idx_q   <= '0;
            phase_q <= PH_PRE;
          end
        end
        PH_PRE: begin
          we_q   <= 1'b1;
          addr_q <= ADDR_W'(idx_q);
          data_q <= (idx_q == 3'(LEAD_LEN - 1)) ? SYNC_BYTE : LEAD_BYTE;
          idx_q  <= idx_q + 3'd1;
          if (idx_q == 3'(LEAD_LEN - 1)) phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // commit lands on the edge that issues the sync-byte write
  for (genvar s = 0; s < 2; s++) begin : g_commit
    assign commit_o[s] = (phase_q == PH_PRE) && (idx_q == 3'(LEAD_LEN - 1)) && (slot_q == 1'(s));
  end
  assign commit_cnt_o = CNT_W'(len_q + LEN_W'(OVERHEAD));

  assign buf_we_o   = we_q;
  assign buf_slot_o = slot_q;
  assign buf_addr_o = addr_q;
  assign buf_data_o = data_q;
  assign busy_o     = !idle;

endmodule

// File: rtl/rx_frame_slots.sv
module rx_frame_slots
  import rxs_pkg::*;
#(
  parameter int unsigned BUF_BYTES   = 2048,
  parameter int unsigned MIN_PAYLOAD = 60,
  localparam int unsigned ADDR_W     = $clog2(BUF_BYTES),
  localparam int unsigned CNT_W      = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  output logic              in_ready_o,
  input  logic              st_we_i,
  input  logic              st_sel_i,
  input  logic [1:0]        st_data_i,
  output logic              buf_we_o,
  output logic              buf_slot_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [7:0]        buf_data_o,
  output logic [1:0]        state0_o,
  output logic [1:0]        state1_o,
  output logic [CNT_W-1:0]  count0_o,
  output logic [CNT_W-1:0]  count1_o,
  output logic              irq_o
);

  logic [1:0]       loaded, pending, commit;
  logic [CNT_W-1:0] commit_cnt;
  logic [1:0]       slot_state [2];
  logic [CNT_W-1:0] slot_cnt   [2];
  logic             crc_clear, crc_en, seq_busy;
  logic [7:0]       crc_data;
  logic [31:0]      crc_val;

  for (genvar s = 0; s < 2; s++) begin : g_slot
    rxs_slot #(.CNT_W(CNT_W)) u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .host_we_i    (st_we_i && (st_sel_i == 1'(s))),
      .host_state_i (st_data_i),
      .commit_i     (commit[s]),
      .commit_cnt_i (commit_cnt),
      .state_o      (slot_state[s]),
      .count_o      (slot_cnt[s])
    );
    assign loaded[s]  = (slot_state[s] == SLOT_LOADED);
    assign pending[s] = (slot_state[s] == SLOT_PENDING);
  end

  rxs_crc u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (crc_clear),
    .en_i    (crc_en),
    .data_i  (crc_data),
    .crc_o   (crc_val)
  );

  rxs_seq #(
    .BUF_BYTES   (BUF_BYTES),
    .MIN_PAYLOAD (MIN_PAYLOAD),
    .ADDR_W      (ADDR_W),
    .CNT_W       (CNT_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (in_valid_i),
    .in_data_i    (in_data_i),
    .in_sop_i     (in_sop_i),
    .in_eop_i     (in_eop_i),
    .in_ready_o   (in_ready_o),
    .loaded_i     (loaded),
    .commit_o     (commit),
    .commit_cnt_o (commit_cnt),
    .crc_clear_o  (crc_clear),
    .crc_en_o     (crc_en),
    .crc_data_o   (crc_data),
    .crc_i        (crc_val),
    .buf_we_o     (buf_we_o),
    .buf_slot_o   (buf_slot_o),
    .buf_addr_o   (buf_addr_o),
    .buf_data_o   (buf_data_o),
    .busy_o       (seq_busy)
  );

  assign state0_o = slot_state[0];
  assign state1_o = slot_state[1];
  assign count0_o = slot_cnt[0];
  assign count1_o = slot_cnt[1];
  assign irq_o    = |pending;

endmodule

// File: rtl/rxs_checker.sv
module rxs_checker #(
  parameter int unsigned ADDR_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_ready_o,
  input logic              st_we_i,
  input logic              st_sel_i,
  input logic              buf_we_o,
  input logic              buf_slot_o,
  input logic [ADDR_W-1:0] buf_addr_o,
  input logic [7:0]        buf_data_o,
  input logic [1:0]        state0_o,
  input logic [1:0]        state1_o,
  input logic              irq_o,
  input logic              busy_i
);

  logic sync_wr;
  assign sync_wr = buf_we_o && (buf_addr_o == ADDR_W'(7));

  p_lead_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_we_o && buf_addr_o < ADDR_W'(7)) |-> buf_data_o == 8'h55);

  p_sync_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_wr |-> buf_data_o == 8'hD5);

  p_pend0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(state0_o == 2'd2) && !$past(st_we_i && !st_sel_i)) |-> (sync_wr && !buf_slot_o));

  p_pend1_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(state1_o == 2'd2) && !$past(st_we_i && st_sel_i)) |-> (sync_wr && buf_slot_o));

  p_hold0_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_we_i |=> ($stable(state0_o) || (sync_wr && !buf_slot_o)));

  p_hold1_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_we_i |=> ($stable(state1_o) || (sync_wr && buf_slot_o)));

  p_irq_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(st_we_i) || sync_wr));

  p_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && state0_o != 2'd1 && state1_o != 2'd1) |-> !in_ready_o);

endmodule

bind rx_frame_slots rxs_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_ready_o (in_ready_o),
  .st_we_i    (st_we_i),
  .st_sel_i   (st_sel_i),
  .buf_we_o   (buf_we_o),
  .buf_slot_o (buf_slot_o),
  .buf_addr_o (buf_addr_o),
  .buf_data_o (buf_data_o),
  .state0_o   (state0_o),
  .state1_o   (state1_o),
  .irq_o      (irq_o),
  .busy_i     (seq_busy)
);

// File: tb/tb_rx_frame_slots.sv
`timescale 1ns/1ps
module tb_rx_frame_slots;
  localparam int BUF = 2048;
  localparam int MINP = 60;
  localparam int AW = 11;
  localparam int CW = 12;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0] in_data = '0;
  logic st_we = 1'b0, st_sel = 1'b0;
  logic [1:0] st_data = '0;
  logic in_ready_o, buf_we_o, buf_slot_o, irq_o;
  logic [AW-1:0] buf_addr_o;
  logic [7:0] buf_data_o;
  logic [1:0] state0_o, state1_o;
  logic [CW-1:0] count0_o, count1_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [1:0] exp_state [2];
  int exp_cnt [2];
  logic [7:0] mem [2][BUF];
  logic [7:0] expb [BUF];

  always #2.5 clk = ~clk;

  rx_frame_slots dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_sop_i(in_sop), .in_eop_i(in_eop),
    .in_ready_o(in_ready_o),
    .st_we_i(st_we), .st_sel_i(st_sel), .st_data_i(st_data),
    .buf_we_o(buf_we_o), .buf_slot_o(buf_slot_o), .buf_addr_o(buf_addr_o), .buf_data_o(buf_data_o),
    .state0_o(state0_o), .state1_o(state1_o), .count0_o(count0_o), .count1_o(count1_o),
    .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, expv);
    end
  endtask

  // per-cycle reference comparison and buffer capture
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk(state0_o == exp_state[0], "R1 slot0 state", state0_o, exp_state[0]);
      chk(state1_o == exp_state[1], "R1 slot1 state", state1_o, exp_state[1]);
      chk(count0_o == CW'(exp_cnt[0]), "R6 slot0 count", count0_o, exp_cnt[0]);
      chk(count1_o == CW'(exp_cnt[1]), "R6 slot1 count", count1_o, exp_cnt[1]);
      chk(irq_o == (exp_state[0] == 2'd2 || exp_state[1] == 2'd2), "R8 irq level",
          irq_o, (exp_state[0] == 2'd2 || exp_state[1] == 2'd2));
      if (buf_we_o) mem[buf_slot_o][buf_addr_o] = buf_data_o;
    end
  end

  function automatic logic [31:0] ref_fcs(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        if (c[0] ^ expb[8+i][b]) c = (c >> 1) ^ 32'hEDB88320;
        else c = c >> 1;
      end
    end
    return ~c;
  endfunction

  task automatic host_wr(input bit s, input logic [1:0] v);
    @(negedge clk);
    st_we = 1'b1; st_sel = s; st_data = v;
    @(posedge clk);
    exp_state[s] = v;
    @(negedge clk);
    st_we = 1'b0;
  endtask

  task automatic send(input int len, input int seed, input bit hw, input bit hw_sel, input logic [1:0] hw_val);
    int s, pad, plen, mm;
    logic [31:0] f;
    s = (exp_state[0] == 2'd1) ? 0 : 1;
    for (int j = 0; j < BUF; j++) mem[s][j] = 8'hEE;
    pad = (len < MINP) ? MINP - len : 0;
    plen = len + pad;
    for (int j = 0; j < 7; j++) expb[j] = 8'h55;
    expb[7] = 8'hD5;
    for (int k = 0; k < len && 8 + k < BUF; k++) expb[8+k] = 8'((seed + 7 * k) & 255);
    for (int k = len; k < plen; k++) expb[8+k] = 8'h00;
    if (plen + 12 <= BUF) begin
      f = ref_fcs(plen);
      for (int k = 0; k < 4; k++) expb[8+plen+k] = f[8*k +: 8];
    end
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'((seed + 7 * k) & 255);
      in_sop = (k == 0); in_eop = (k == len - 1);
      while (!in_ready_o) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    if (len > BUF - 12) begin
      chk(in_ready_o == (exp_state[0] == 2'd1 || exp_state[1] == 2'd1), "R9 ready after dropped frame", in_ready_o, 1);
      repeat (20) @(negedge clk);
      mm = 0;
      for (int j = BUF - 4; j < BUF; j++) if (mem[s][j] !== 8'hEE) mm++;
      chk(mm == 0, "R7 no write past limit", mm, 0);
      return;
    end
    chk(in_ready_o == 1'b0, "R9 ready low after end beat", in_ready_o, 0);
    repeat (pad + 11) @(posedge clk);
    @(negedge clk);
    if (hw) begin st_we = 1'b1; st_sel = hw_sel; st_data = hw_val; end
    @(posedge clk);
    exp_state[s] = 2'd2;
    exp_cnt[s] = plen + 12;
    if (hw && hw_sel != 1'(s)) exp_state[hw_sel] = hw_val;
    @(negedge clk);
    st_we = 1'b0;
    chk(((s == 0) ? state0_o : state1_o) == 2'd2, "R2 chosen slot pending", s, s);
    @(negedge clk);
    mm = 0;
    for (int j = 0; j < 8; j++) if (mem[s][j] !== expb[j]) mm++;
    chk(mm == 0, "R3 leading bytes", mm, 0);
    mm = 0;
    for (int j = 8; j < 8 + len; j++) if (mem[s][j] !== expb[j]) mm++;
    chk(mm == 0, "R3 payload bytes", mm, 0);
    mm = 0;
    for (int j = 8 + len; j < 8 + plen; j++) if (mem[s][j] !== 8'h00) mm++;
    chk(mm == 0, "R4 pad bytes", mm, 0);
    mm = 0;
    for (int j = 8 + plen; j < 12 + plen; j++) if (mem[s][j] !== expb[j]) mm++;
    chk(mm == 0, "R5 check bytes", mm, 0);
  endtask

  initial begin
    exp_state[0] = 2'd0; exp_state[1] = 2'd0; exp_cnt[0] = 0; exp_cnt[1] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(state0_o == 2'd0 && state1_o == 2'd0, "R1 reset states", state0_o, 0);
    chk(irq_o == 1'b0, "R8 reset irq", irq_o, 0);
    chk(in_ready_o == 1'b0, "R9 no slot loaded", in_ready_o, 0);

    // offer a start byte with nothing loaded
    in_valid = 1'b1; in_sop = 1'b1; in_data = 8'h11;
    repeat (5) @(negedge clk);
    chk(in_ready_o == 1'b0, "R9 stall without slot", in_ready_o, 0);
    chk(buf_we_o == 1'b0, "R9 no write without slot", buf_we_o, 0);
    in_valid = 1'b0; in_sop = 1'b0;

    host_wr(1'b1, 2'd1);
    chk(in_ready_o == 1'b1, "R9 ready with slot loaded", in_ready_o, 1);
    send(20, 3, 0, 0, 2'd0);            // short frame into slot 1, padded
    host_wr(1'b1, 2'd0);
    chk(irq_o == 1'b0, "R8 irq drops after release", irq_o, 0);

    host_wr(1'b0, 2'd1);
    host_wr(1'b1, 2'd1);
    send(64, 9, 0, 0, 2'd0);            // slot 0 preferred
    send(61, 40, 0, 0, 2'd0);           // slot 1 next
    chk(in_ready_o == 1'b0, "R9 both pending", in_ready_o, 0);

    host_wr(1'b0, 2'd0);
    host_wr(1'b1, 2'd0);
    host_wr(1'b0, 2'd1);
    // byte without start marker while idle
    @(negedge clk);
    in_valid = 1'b1; in_sop = 1'b0; in_eop = 1'b1; in_data = 8'hAA;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_eop = 1'b0;
    chk(buf_we_o == 1'b0, "R10 stray byte not written", buf_we_o, 0);
    chk(in_ready_o == 1'b1, "R10 still idle", in_ready_o, 1);
    send(1, 77, 0, 0, 2'd0);            // single-byte frame into slot 0

    host_wr(1'b1, 2'd1);
    send(BUF - 11, 5, 0, 0, 2'd0);      // one byte too long: dropped (R7)
    chk(state1_o == 2'd1, "R7 state kept", state1_o, 1);
    send(BUF - 12, 6, 0, 0, 2'd0);      // largest fitting frame (R6)
    chk(count1_o == CW'(BUF), "R6 full count", count1_o, BUF);

    // coincident host write and commit (R11)
    host_wr(1'b0, 2'd1);
    host_wr(1'b1, 2'd0);
    send(60, 21, 1, 1'b0, 2'd0);
    chk(state0_o == 2'd2, "R11 commit beats same-slot write", state0_o, 2);
    host_wr(1'b1, 2'd1);
    send(30, 33, 1, 1'b0, 2'd0);
    chk(state0_o == 2'd0 && state1_o == 2'd2, "R11 other-slot write applied", state0_o, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule